// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary ownership tokens that two independent ports, called left and right, use to coordinate access to a shared resource. The tokens live in their own address space. A port reaches it by asserting its semaphore select while its memory enable is low. The low address bits pick one token. Bit 0 of the write data either asks for the token or gives it back, and the token is active low.

Each port sees a token as 0 when it holds it and as 1 otherwise. Each side has a request latch for every token. A side that asks for a token the other side holds is queued, and the token moves to it in the same update in which the holder releases it. A read captures the token value at the start of the read, copies it onto every data bit and holds it until the read ends. The whole block is synchronous to one clock.

Top module: `twoport_sem_bank`

## Requirements
- R1: There are N = 8 tokens, indexed by address bits [2:0]. Address bits above bit 2 have no effect on writes or on reads.
- R2: A semaphore write looks only at data bit 0, where 0 asks for the token and 1 gives it back. Data bits 8 to 1 are ignored.
- R3: A request to a free token grants it. After the grant the requester reads 0 and the other side reads 1. The two sides never hold the same token at once. A holder keeps its token until it writes a 1 to it.
- R4: A request from the side that does not hold the token is latched. When the holder releases, the waiting side gets the token in that same clock update.
- R5: If the holder releases and no request is waiting, the token becomes free and both sides read 1.
- R6: A read returns the token value copied onto all 9 data bits. The value appears on the clock edge that first samples the read as active.
- R7: The read value stays frozen for as long as select, read enable and a low memory enable all stay active. A new value needs the read to drop and start again.
- R8: If both sides request the same free token in the same cycle, left is granted and right's request is latched.
- R9: The semaphore space is reached only with semaphore select 1 and memory enable 0. Under any other combination, writes are ignored and read data is 0. Read data is also 0 whenever no read is active.
- R10: After reset every token is free, no request is latched, and both read data outputs are 0.
- R11: A 1 written by a side that neither holds the token nor has a request waiting is ignored. A 1 written by the waiting side cancels its waiting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lft_mem_en | input | 1 | Left data-memory enable; must be 0 for semaphore access |
| lft_sem_sel | input | 1 | Left semaphore-space select |
| lft_wr | input | 1 | Left write strobe, one write per cycle it is high |
| lft_rd | input | 1 | Left read (output) enable |
| lft_addr | input | AW (14) | Left address; bits [2:0] pick the token |
| lft_wdata | input | DW (9) | Left write data; bit 0 used |
| lft_rdata | output | DW (9) | Left captured token value, replicated |
| rgt_mem_en | input | 1 | Right data-memory enable; must be 0 for semaphore access |
| rgt_sem_sel | input | 1 | Right semaphore-space select |
| rgt_wr | input | 1 | Right write strobe |
| rgt_rd | input | 1 | Right read (output) enable |
| rgt_addr | input | AW (14) | Right address; bits [2:0] pick the token |
| rgt_wdata | input | DW (9) | Right write data; bit 0 used |
| rgt_rdata | output | DW (9) | Right captured token value, replicated |

## Verification
A write changes token ownership and the latched requests on the clock edge that samples it. Read data appears on the edge that first sees the read active, which is one edge after the inputs are driven. The bench drives every input on the falling edge and compares read data on the next falling edge. Each write is followed by a separate read, so every comparison sees the token state after the whole write has settled. For the freeze test, a write is issued while a read is held. The frozen value is checked on the falling edge after that write, and the new value is checked only after the read has been dropped and started again.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  // A port reaches the token space only with select high and memory enable low.
  function automatic logic sem_access(input logic mem_en, input logic sem_sel);
    return sem_sel & ~mem_en;
  endfunction

  // Active-low token: a written 0 asks for ownership.
  function automatic logic asks_token(input logic data_bit0);
    return ~data_bit0;
  endfunction

  // Value a side sees: 0 when it holds the token, 1 otherwise.
  function automatic logic side_view(input logic holds);
    return ~holds;
  endfunction

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int N  = 8,
  parameter int AW = 14,
  parameter int DW = 9
) (
  input  logic                  mem_en,
  input  logic                  sem_sel,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [N-1:0]          hit,
  output logic                  wbit,
  output logic                  rd_active,
  output logic [$clog2(N)-1:0]  rd_idx
);
  import sem_bank_pkg::*;

  localparam int IW = $clog2(N);

  logic            acc;
  logic            wr_ok;
  logic [IW-1:0]   idx;
  logic            unused_hi;

  assign acc       = sem_access(mem_en, sem_sel);
  assign wr_ok     = acc & wr;
  assign idx       = addr[IW-1:0];
  assign wbit      = wdata[0];
  assign rd_active = acc & rd;
  assign rd_idx    = idx;
  assign unused_hi = ^{addr[AW-1:IW], wdata[DW-1:1]};

  for (genvar k = 0; k < N; k++) begin : g_hit
    assign hit[k] = wr_ok && (idx == IW'(k));
  end

endmodule

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic bit_l,
  input  logic wr_r,
  input  logic bit_r,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);
  import sem_bank_pkg::*;

  logic req_l, req_r, rel_l, rel_r;
  logic eff_pl, eff_pr;
  logic n_ol, n_or, n_pl, n_pr;

  assign req_l  = wr_l & asks_token(bit_l);
  assign req_r  = wr_r & asks_token(bit_r);
  assign rel_l  = wr_l & bit_l;
  assign rel_r  = wr_r & bit_r;
  // A write from a side overrides its latch: 0 queues, 1 cancels.
  assign eff_pl = wr_l ? req_l : pend_l;
  assign eff_pr = wr_r ? req_r : pend_r;

  always_comb begin
    n_ol = own_l;
    n_or = own_r;
    n_pl = eff_pl;
    n_pr = eff_pr;
    if (!own_l && !own_r) begin
      if (req_l) begin
        n_ol = 1'b1;
        n_pl = 1'b0;
      end else if (req_r) begin
        n_or = 1'b1;
        n_pr = 1'b0;
      end
    end else if (own_l) begin
      n_pl = 1'b0;
      if (rel_l) begin
        n_ol = 1'b0;
        if (eff_pr) begin
          n_or = 1'b1;
          n_pr = 1'b0;
        end
      end
    end else begin
      n_pr = 1'b0;
      if (rel_r) begin
        n_or = 1'b0;
        if (eff_pl) begin
          n_ol = 1'b1;
          n_pl = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_l  <= 1'b0;
      own_r  <= 1'b0;
      pend_l <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      own_l  <= n_ol;
      own_r  <= n_or;
      pend_l <= n_pl;
      pend_r <= n_pr;
    end
  end

endmodule

// File: rtl/sem_read_hold.sv
module sem_read_hold #(
  parameter int N  = 8,
  parameter int DW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_active,
  input  logic [N-1:0]         flags,
  input  logic [$clog2(N)-1:0] idx,
  output logic [DW-1:0]        rdata
);
  logic cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      rdata <= '0;
    end else begin
      cap_q <= rd_active;
      if (!rd_active) begin
        rdata <= '0;
      end else if (!cap_q) begin
        rdata <= {DW{flags[idx]}};
      end
    end
  end

endmodule

// File: rtl/twoport_sem_bank.sv
module twoport_sem_bank #(
  parameter int N  = 8,
  parameter int AW = 14,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lft_mem_en,
  input  logic          lft_sem_sel,
  input  logic          lft_wr,
  input  logic          lft_rd,
  input  logic [AW-1:0] lft_addr,
  input  logic [DW-1:0] lft_wdata,
  output logic [DW-1:0] lft_rdata,
  input  logic          rgt_mem_en,
  input  logic          rgt_sem_sel,
  input  logic          rgt_wr,
  input  logic          rgt_rd,
  input  logic [AW-1:0] rgt_addr,
  input  logic [DW-1:0] rgt_wdata,
  output logic [DW-1:0] rgt_rdata
);
  import sem_bank_pkg::*;

  localparam int IW = $clog2(N);

  logic [N-1:0]  hit_l, hit_r;
  logic          wbit_l, wbit_r;
  logic          rd_act_l, rd_act_r;
  logic [IW-1:0] idx_l, idx_r;
  logic [N-1:0]  own_l, own_r, pend_l, pend_r;
  logic [N-1:0]  flag_l, flag_r;

  sem_port_dec #(.N(N), .AW(AW), .DW(DW)) u_dec_l (
    .mem_en(lft_mem_en), .sem_sel(lft_sem_sel), .wr(lft_wr), .rd(lft_rd),
    .addr(lft_addr), .wdata(lft_wdata), .hit(hit_l), .wbit(wbit_l),
    .rd_active(rd_act_l), .rd_idx(idx_l)
  );

  sem_port_dec #(.N(N), .AW(AW), .DW(DW)) u_dec_r (
    .mem_en(rgt_mem_en), .sem_sel(rgt_sem_sel), .wr(rgt_wr), .rd(rgt_rd),
    .addr(rgt_addr), .wdata(rgt_wdata), .hit(hit_r), .wbit(wbit_r),
    .rd_active(rd_act_r), .rd_idx(idx_r)
  );

  for (genvar k = 0; k < N; k++) begin : g_tok
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_l(hit_l[k]), .bit_l(wbit_l),
      .wr_r(hit_r[k]), .bit_r(wbit_r),
      .own_l(own_l[k]), .own_r(own_r[k]),
      .pend_l(pend_l[k]), .pend_r(pend_r[k])
    );
    assign flag_l[k] = side_view(own_l[k]);
    assign flag_r[k] = side_view(own_r[k]);
  end

  sem_read_hold #(.N(N), .DW(DW)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd_active(rd_act_l),
    .flags(flag_l), .idx(idx_l), .rdata(lft_rdata)
  );

  sem_read_hold #(.N(N), .DW(DW)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd_active(rd_act_r),
    .flags(flag_r), .idx(idx_r), .rdata(rgt_rdata)
  );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int N  = 8,
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  own_l,
  input logic [N-1:0]  own_r,
  input logic [N-1:0]  pend_r,
  input logic [N-1:0]  hit_l,
  input logic [N-1:0]  hit_r,
  input logic          wbit_l,
  input logic          wbit_r,
  input logic          rd_act_l,
  input logic          rd_act_r,
  input logic [DW-1:0] lft_rdata,
  input logic [DW-1:0] rgt_rdata
);

  for (genvar k = 0; k < N; k++) begin : g_prop
    p_owner_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_l[k] && own_r[k]));

    p_left_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[k] && !(hit_l[k] && wbit_l) |=> own_l[k]);

    p_right_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      own_r[k] && !(hit_r[k] && wbit_r) |=> own_r[k]);

    p_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[k] && hit_l[k] && wbit_l && pend_r[k] && !hit_r[k] |=> own_r[k]);

    p_free_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[k] && hit_l[k] && wbit_l && !pend_r[k] && !hit_r[k]
      |=> !own_l[k] && !own_r[k]);

    p_tie_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !own_l[k] && !own_r[k] && hit_l[k] && !wbit_l && hit_r[k] && !wbit_r
      |=> own_l[k] && pend_r[k]);
  end

  p_replicate_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_rdata == '0) || (lft_rdata == '1));

  p_replicate_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_rdata == '0) || (rgt_rdata == '1));

  p_hold_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_l && $past(rd_act_l) |=> $stable(lft_rdata));

  p_hold_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_r && $past(rd_act_r) |=> $stable(rgt_rdata));

  p_idle_zero_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act_l |=> lft_rdata == '0);

  p_idle_zero_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act_r |=> rgt_rdata == '0);

endmodule

bind twoport_sem_bank sem_bank_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .own_l(own_l), .own_r(own_r), .pend_r(pend_r),
  .hit_l(hit_l), .hit_r(hit_r), .wbit_l(wbit_l), .wbit_r(wbit_r),
  .rd_act_l(rd_act_l), .rd_act_r(rd_act_r),
  .lft_rdata(lft_rdata), .rgt_rdata(rgt_rdata)
);

// File: tb/tb_twoport_sem_bank.sv
`timescale 1ns/1ps
module tb_twoport_sem_bank;
  localparam int N = 8, AW = 14, DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lft_mem_en = 0, lft_sem_sel = 0, lft_wr = 0, lft_rd = 0;
  logic rgt_mem_en = 0, rgt_sem_sel = 0, rgt_wr = 0, rgt_rd = 0;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic [DW-1:0] lft_wdata = '0, rgt_wdata = '0;
  logic [DW-1:0] lft_rdata, rgt_rdata;

  int n_chk = 0, n_err = 0;
  int owner [N];   // 0 free, 1 left, 2 right
  bit wait_l [N];
  bit wait_r [N];

  always #4 clk = ~clk;

  twoport_sem_bank #(.N(N), .AW(AW), .DW(DW)) dut (.*);

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected view of a token from one side (side 1 = left, 2 = right).
  function automatic logic [DW-1:0] seen(input int side, input int k);
    return (owner[k] == side) ? '0 : '1;
  endfunction

  // Reference update of one token for the writes that hit it in one cycle.
  task automatic ref_step(input int k, input bit lw, input bit lb, input bit rw, input bit rb);
    bit lq, rq;
    lq = lw && !lb;
    rq = rw && !rb;
    if (owner[k] == 0) begin
      if (lq) begin owner[k] = 1; wait_r[k] = rq; end
      else if (rq) owner[k] = 2;
    end else if (owner[k] == 1) begin
      if (rw) wait_r[k] = rq;
      if (lw && lb) begin
        owner[k] = wait_r[k] ? 2 : 0;
        wait_r[k] = 0;
      end
    end else begin
      if (lw) wait_l[k] = lq;
      if (rw && rb) begin
        owner[k] = wait_l[k] ? 1 : 0;
        wait_l[k] = 0;
      end
    end
  endtask

  // Enters and leaves on a falling edge; one write cycle per side.
  task automatic wr2(input bit lw, input int li, input bit lb,
                     input bit rw, input int ri, input bit rb,
                     input bit lbad = 0, input bit rbad = 0);
    lft_sem_sel = lw; lft_mem_en = lbad; lft_wr = lw;
    lft_addr = {AW'($urandom) >> 3, 3'(li)};
    lft_wdata = {8'($urandom), lb};
    rgt_sem_sel = rw; rgt_mem_en = rbad; rgt_wr = rw;
    rgt_addr = {AW'($urandom) >> 3, 3'(ri)};
    rgt_wdata = {8'($urandom), rb};
    @(negedge clk);
    lft_sem_sel = 0; lft_mem_en = 0; lft_wr = 0;
    rgt_sem_sel = 0; rgt_mem_en = 0; rgt_wr = 0;
    for (int k = 0; k < N; k++) begin
      bit a, b;
      a = lw && !lbad && (li == k);
      b = rw && !rbad && (ri == k);
      if (a || b) ref_step(k, a, lb, b, rb);
    end
  endtask

  // Read both sides and compare on the falling edge after capture.
  task automatic rd2(input string req, input int li, input int ri, input bit bad = 0);
    lft_sem_sel = 1; lft_rd = 1; lft_mem_en = bad;
    lft_addr = {AW'($urandom) >> 3, 3'(li)};
    rgt_sem_sel = 1; rgt_rd = 1; rgt_mem_en = bad;
    rgt_addr = {AW'($urandom) >> 3, 3'(ri)};
    @(negedge clk);
    chk({req, " left"},  lft_rdata, bad ? '0 : seen(1, li));
    chk({req, " right"}, rgt_rdata, bad ? '0 : seen(2, ri));
    lft_sem_sel = 0; lft_rd = 0; lft_mem_en = 0;
    rgt_sem_sel = 0; rgt_rd = 0; rgt_mem_en = 0;
    @(negedge clk);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'h5EA0_0001);
    for (int k = 0; k < N; k++) begin owner[k] = 0; wait_l[k] = 0; wait_r[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10: reset state
    chk("R10 left idle", lft_rdata, '0);
    chk("R10 right idle", rgt_rdata, '0);
    for (int k = 0; k < N; k++) rd2("R10 free after reset", k, k);

    // R3 claim, R4 queue and handoff, R5 release to free (token 5)
    wr2(1, 5, 0, 0, 0, 1);             rd2("R3 left claims", 5, 5);
    wr2(0, 0, 1, 1, 5, 0);             rd2("R4 right queued", 5, 5);
    wr2(0, 0, 1, 1, 5, 1);             rd2("R3 non-owner release no effect", 5, 5);
    wr2(0, 0, 1, 1, 5, 0);
    wr2(1, 5, 1, 0, 0, 1);             rd2("R4 token passes to waiter", 5, 5);
    wr2(0, 0, 1, 1, 5, 1);             rd2("R5 free after release", 5, 5);

    // R8 same-cycle tie on token 2
    wr2(1, 2, 0, 1, 2, 0);             rd2("R8 tie goes left", 2, 2);
    wr2(1, 2, 1, 0, 0, 1);             rd2("R8 queued right takes over", 2, 2);
    wr2(0, 0, 1, 1, 2, 1);             rd2("R5 token 2 free", 2, 2);

    // R11 ignored release and cancel (token 6)
    wr2(0, 0, 1, 1, 6, 1);             rd2("R11 stray release ignored", 6, 6);
    wr2(1, 6, 0, 0, 0, 1);
    wr2(0, 0, 1, 1, 6, 0);
    wr2(0, 0, 1, 1, 6, 1);
    wr2(1, 6, 1, 0, 0, 1);             rd2("R11 cancelled request not granted", 6, 6);

    // R1 high address bits and R2 upper data bits
    lft_sem_sel = 1; lft_wr = 1; lft_addr = 14'h3FF9; lft_wdata = 9'h1FE;
    @(negedge clk);
    lft_sem_sel = 0; lft_wr = 0;
    ref_step(1, 1, 0, 0, 1);
    rd2("R1 R2 token 1 via high bits", 1, 1);
    lft_sem_sel = 1; lft_wr = 1; lft_addr = 14'h2A01; lft_wdata = 9'h001;
    @(negedge clk);
    lft_sem_sel = 0; lft_wr = 0;
    ref_step(1, 1, 1, 0, 1);
    rd2("R2 release with upper bits zero", 1, 1);

    // R9 illegal select combination
    wr2(1, 3, 0, 1, 4, 0, 1, 1);       rd2("R9 write with memory enable ignored", 3, 4);
    wr2(1, 3, 0, 0, 0, 1);             rd2("R9 read with memory enable gives zero", 3, 3, 1);
    wr2(1, 3, 1, 0, 0, 1);

    // R7 frozen read: hold a left read of token 0, claim it underneath
    lft_sem_sel = 1; lft_rd = 1; lft_addr = 14'h0000;
    @(negedge clk);
    chk("R6 R7 captured free", lft_rdata, '1);
    lft_wr = 1; lft_wdata = 9'h000;
    @(negedge clk);
    lft_wr = 0;
    ref_step(0, 1, 0, 0, 1);
    @(negedge clk);
    chk("R7 frozen during hold", lft_rdata, '1);
    lft_rd = 0;
    @(negedge clk);
    chk("R9 zero between reads", lft_rdata, '0);
    lft_rd = 1;
    @(negedge clk);
    chk("R7 new value after re-read", lft_rdata, '0);
    lft_rd = 0; lft_sem_sel = 0;
    @(negedge clk);

    // Random mix: R1 R2 R3 R4 R5 R6 R8 R11 against the reference
    for (int it = 0; it < 400; it++) begin
      bit lw, rw, lb, rb;
      int li, ri;
      lw = ($urandom % 3) != 0;
      rw = ($urandom % 3) != 0;
      lb = $urandom % 2;
      rb = $urandom % 2;
      li = $urandom % 4;
      ri = $urandom % 4;
      wr2(lw, li, lb, rw, ri, rb);
      rd2("R6 random read", $urandom % N, $urandom % N);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule